// File: doc/BRIEF.md
# Single-Wire Bus Bit-Timing Master

This block is the bit-level master for a single-wire, open-drain bus. The user side starts one operation at a time: a bus reset with a presence check, a write of one bit, or a read of one bit. The engine then drives an active-high pull-low enable toward the pad and samples the line through a synchronizer. It never drives the line high. When the line is released, an external pull-up brings it high.

All timing runs from a one-microsecond tick. The tick is divided down from the system clock, whose frequency is a parameter. The master opens every slot by pulling the line low. A slave answers a read slot with a 0 by holding the line low after the master has let go. A slave announces itself after reset by pulling the line low for a while once the line has risen. Each operation ends with a released recovery interval. After that interval, done is pulsed for one clock and the sampled result is shown on a held output.

Top module: `owm_engine`

## Requirements
- R1: After reset, busy, done, pull_low, presence and rd_bit are all 0. A start pulse while idle with a valid code makes busy and pull_low go to 1 on the accepting clock edge. The operation codes are 0 for reset, 1 for write (the bit comes from wr_bit) and 2 for read.
- R2: A reset operation holds pull_low at 1 for exactly RST_LOW_US microseconds (default 480) and then releases the line.
- R3: A reset samples the line PRES_SAMPLE_US microseconds (default 70) after release. presence becomes 1 if the line was low at that point and 0 if it was high.
- R4: A reset operation lasts RST_LOW_US + RST_RX_US + RECOVER_US microseconds from the accepting edge to the edge that raises done (default 965). RST_LOW_US + RECOVER_US is kept below 960.
- R5: A write with wr_bit 0 holds pull_low for SLOT_US microseconds (default 60). The operation lasts SLOT_US + RECOVER_US microseconds.
- R6: A write with wr_bit 1 holds pull_low for WR1_LOW_US microseconds (default 6). It still lasts SLOT_US + RECOVER_US microseconds.
- R7: A read holds pull_low for RD_LOW_US microseconds (default 6) and samples the line at RD_SAMPLE_US (default 15) into rd_bit: 1 if the line was high, 0 if it was low. It lasts SLOT_US + RECOVER_US microseconds.
- R8: done is high for exactly one clock. busy falls in that same clock. The line has been released for at least RECOVER_US microseconds at that point.
- R9: A start pulse while busy is ignored. The running operation keeps its code, its low time and its length.
- R10: pull_low is never 1 while busy is 0.
- R11: A start with operation code 3 is ignored. busy and pull_low stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an operation (accepted only while idle) |
| op | input | 2 | Operation code: 0 reset, 1 write, 2 read, 3 unused |
| wr_bit | input | 1 | Bit value for a write operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse at the end of an operation |
| presence | output | 1 | Result of the last presence check |
| rd_bit | output | 1 | Result of the last read slot |
| pull_low | output | 1 | Active-high enable for the open-drain pull-down |
| line_in | input | 1 | Bus line level, asynchronous |

## Verification
The hardest case to reach from the ports is the presence sample. It depends on a slave that pulls the line low only after the master has released it, and the sample falls inside a window that lies hundreds of microseconds after the start pulse. The bench models the slave as open-drain with a wired AND against pull_low. It schedules the slave's low interval as a count of clocks from the accepting edge, so that the low interval brackets the sample point when a slave is present and is left out when none is. A second case is a start pulse injected in the middle of a slot with a different code. It is handled by checking that the low time and the length still match the operation that was first accepted.

// File: rtl/owm_pkg.sv
package owm_pkg;
   typedef enum logic [1:0] {
      OWM_OP_RESET = 2'd0,
      OWM_OP_WRITE = 2'd1,
      OWM_OP_READ  = 2'd2,
      OWM_OP_NONE  = 2'd3
   } owm_op_e;
endpackage

// File: rtl/owm_tick_gen.sv
module owm_tick_gen #(
   parameter int DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV <= 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (clr)         cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/owm_line_sync.sv
module owm_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '1;
      else        ff <= {ff[STAGES-2:0], d};
   end
   assign q = ff[STAGES-1];
endmodule

// File: rtl/owm_slot_seq.sv
module owm_slot_seq
   import owm_pkg::*;
#(
   parameter int RST_LOW_US     = 480,
   parameter int RST_RX_US      = 480,
   parameter int PRES_SAMPLE_US = 70,
   parameter int SLOT_US        = 60,
   parameter int WR1_LOW_US     = 6,
   parameter int RD_LOW_US      = 6,
   parameter int RD_SAMPLE_US   = 15,
   parameter int RECOVER_US     = 5
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    us_tick,
   input  logic    start,
   input  owm_op_e op,
   input  logic    wr_bit,
   input  logic    line_s,
   output logic    tick_clr,
   output logic    busy,
   output logic    done,
   output logic    pull_low,
   output logic    presence,
   output logic    rd_bit,
   output owm_op_e cur_op
);
   localparam int RST_TOTAL  = RST_LOW_US + RST_RX_US + RECOVER_US;
   localparam int SLOT_TOTAL = SLOT_US + RECOVER_US;
   localparam int MAX_TOTAL  = (RST_TOTAL > SLOT_TOTAL) ? RST_TOTAL : SLOT_TOTAL;
   localparam int CW         = $clog2(MAX_TOTAL + 1);

   logic          bit_q;
   logic [CW-1:0] us_cnt, cnt_nxt;
   logic [CW-1:0] low_len, smp_at, tot_len;
   logic          accept;

   assign accept   = !busy && start && (op != OWM_OP_NONE);
   assign tick_clr = accept;
   assign cnt_nxt  = us_cnt + 1'b1;

   always_comb begin
      unique case (cur_op)
         OWM_OP_RESET: begin
            low_len = CW'(RST_LOW_US);
            smp_at  = CW'(RST_LOW_US + PRES_SAMPLE_US);
            tot_len = CW'(RST_TOTAL);
         end
         OWM_OP_WRITE: begin
            low_len = bit_q ? CW'(WR1_LOW_US) : CW'(SLOT_US);
            smp_at  = '0;
            tot_len = CW'(SLOT_TOTAL);
         end
         default: begin
            low_len = CW'(RD_LOW_US);
            smp_at  = CW'(RD_SAMPLE_US);
            tot_len = CW'(SLOT_TOTAL);
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         pull_low <= 1'b0;
         presence <= 1'b0;
         rd_bit   <= 1'b0;
         bit_q    <= 1'b0;
         cur_op   <= OWM_OP_NONE;
         us_cnt   <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (accept) begin
               busy     <= 1'b1;
               pull_low <= 1'b1;
               cur_op   <= op;
               bit_q    <= wr_bit;
               us_cnt   <= '0;
            end
         end else if (us_tick) begin
            us_cnt   <= cnt_nxt;
            pull_low <= (cnt_nxt < low_len);
            if (cnt_nxt == smp_at) begin
               if (cur_op == OWM_OP_RESET) presence <= !line_s;
               if (cur_op == OWM_OP_READ)  rd_bit   <= line_s;
            end
            if (cnt_nxt == tot_len) begin
               busy     <= 1'b0;
               done     <= 1'b1;
               pull_low <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/owm_engine.sv
module owm_engine
   import owm_pkg::*;
#(
   parameter int CLK_HZ         = 100_000_000,
   parameter int RST_LOW_US     = 480,
   parameter int RST_RX_US      = 480,
   parameter int PRES_SAMPLE_US = 70,
   parameter int SLOT_US        = 60,
   parameter int WR1_LOW_US     = 6,
   parameter int RD_LOW_US      = 6,
   parameter int RD_SAMPLE_US   = 15,
   parameter int RECOVER_US     = 5,
   parameter int SYNC_STAGES    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] op,
   input  logic       wr_bit,
   output logic       busy,
   output logic       done,
   output logic       presence,
   output logic       rd_bit,
   output logic       pull_low,
   input  logic       line_in
);
   localparam int TICK_DIV = CLK_HZ / 1_000_000;

   if (TICK_DIV < 1)                          $error("CLK_HZ must be at least 1 MHz");
   if (RST_LOW_US < 480)                      $error("reset low time below 480 us");
   if (RST_LOW_US + RECOVER_US >= 960)        $error("reset low plus recovery reaches 960 us");
   if (PRES_SAMPLE_US >= RST_RX_US)           $error("presence sample after receive period");
   if (RD_SAMPLE_US <= RD_LOW_US)             $error("read sample inside master low time");
   if (SLOT_US <= RD_SAMPLE_US)               $error("read sample outside the slot");
   if (WR1_LOW_US >= SLOT_US)                 $error("write-1 low time fills the slot");
   if (RECOVER_US < 1)                        $error("recovery must be at least 1 us");
   if (SYNC_STAGES < 2)                       $error("synchronizer needs two stages");

   logic    us_tick, tick_clr, line_s;
   owm_op_e cur_op;

   owm_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tick_clr),
      .tick  (us_tick)
   );

   owm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (line_in),
      .q     (line_s)
   );

   owm_slot_seq #(
      .RST_LOW_US     (RST_LOW_US),
      .RST_RX_US      (RST_RX_US),
      .PRES_SAMPLE_US (PRES_SAMPLE_US),
      .SLOT_US        (SLOT_US),
      .WR1_LOW_US     (WR1_LOW_US),
      .RD_LOW_US      (RD_LOW_US),
      .RD_SAMPLE_US   (RD_SAMPLE_US),
      .RECOVER_US     (RECOVER_US)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .us_tick  (us_tick),
      .start    (start),
      .op       (owm_op_e'(op)),
      .wr_bit   (wr_bit),
      .line_s   (line_s),
      .tick_clr (tick_clr),
      .busy     (busy),
      .done     (done),
      .pull_low (pull_low),
      .presence (presence),
      .rd_bit   (rd_bit),
      .cur_op   (cur_op)
   );
endmodule

// File: rtl/owm_engine_chk.sv
module owm_engine_chk #(
   parameter int REC_CYC = 500
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [1:0] op,
   input logic       busy,
   input logic       done,
   input logic       pull_low,
   input logic [1:0] cur_op
);
   logic [15:0] rel_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  rel_cnt <= '0;
      else if (!busy || pull_low)  rel_cnt <= '0;
      else if (rel_cnt != 16'hFFFF) rel_cnt <= rel_cnt + 1'b1;
   end

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !pull_low);                                         // R10
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                              // R8
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (!busy && $past(busy)));                      // R8
   AST_RECOVERY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (32'(rel_cnt) >= REC_CYC));                   // R8
   AST_START_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && op != 2'd3) |=> (busy && pull_low));       // R1
   AST_BUSY_OP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cur_op));                                    // R9
   AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && op == 2'd3) |=> !busy);                    // R11
endmodule

bind owm_engine owm_engine_chk #(.REC_CYC(RECOVER_US * TICK_DIV)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .op       (op),
   .busy     (busy),
   .done     (done),
   .pull_low (pull_low),
   .cur_op   (cur_op)
);

// File: tb/owm_engine_bench.sv
module owm_engine_bench;
   localparam int CLK_HZ  = 4_000_000;
   localparam int DIV     = CLK_HZ / 1_000_000;
   localparam int T_RLOW  = 480;
   localparam int T_RRX   = 480;
   localparam int T_SLOT  = 60;
   localparam int T_W1    = 6;
   localparam int T_RDLOW = 6;
   localparam int T_REC   = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] op = 2'd0;
   logic       wr_bit = 1'b0;
   logic       slave_low = 1'b0;
   logic       busy, done, presence, rd_bit, pull_low, line_in;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;
   assign line_in = !(pull_low || slave_low);

   owm_engine #(.CLK_HZ(CLK_HZ)) u_owm_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wr_bit(wr_bit),
      .busy(busy), .done(done), .presence(presence), .rd_bit(rd_bit),
      .pull_low(pull_low), .line_in(line_in)
   );

   function automatic int exp_low(input logic [1:0] o, input logic b);
      case (o)
         2'd0:    return T_RLOW * DIV;
         2'd1:    return (b ? T_W1 : T_SLOT) * DIV;
         default: return T_RDLOW * DIV;
      endcase
   endfunction

   function automatic int exp_len(input logic [1:0] o);
      return ((o == 2'd0) ? (T_RLOW + T_RRX + T_REC) : (T_SLOT + T_REC)) * DIV + 1;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // Runs one operation. The slave pulls low on negedges lo_from..lo_to-1,
   // counted from the accepting edge. inj > 0 injects a start pulse there.
   task automatic run_op(input logic [1:0] o, input logic b, input int lo_from,
                         input int lo_to, input int inj, input string rq,
                         output int len, output int low);
      int k;
      @(negedge clk);
      start = 1'b1; op = o; wr_bit = b;
      k = 0; low = 0;
      do begin
         @(negedge clk);
         k++;
         start = (inj > 0 && k == inj);
         if (start) begin op = (o == 2'd2) ? 2'd1 : 2'd2; wr_bit = !b; end
         slave_low = (k >= lo_from && k < lo_to);
         if (k == 1) check(busy && pull_low, "R1", busy, 1);
         if (pull_low) low++;
      end while (!done && k < 10000);
      slave_low = 1'b0;
      start = 1'b0;
      len = k;
      check(len == exp_len(o), rq, len, exp_len(o));
      check(low == exp_low(o, b), rq, low, exp_low(o, b));
      check(!busy, "R8", busy, 0);
      @(negedge clk);
      check(!done, "R8", done, 0);
   endtask

   initial begin
      int unsigned cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 190_000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190_000);
            finish_run();
         end
      end
   end

   initial begin
      int len, low, pres_from, pres_to;
      logic [1:0] o;
      logic b, rv;
      void'($urandom(32'h1A2B3C));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !pull_low, "R1", {busy, done, pull_low}, 0);
      check(!presence && !rd_bit, "R1", {presence, rd_bit}, 0);

      // presence window: slave low 30..130 us after release
      pres_from = (T_RLOW + 30) * DIV;
      pres_to   = (T_RLOW + 130) * DIV;
      run_op(2'd0, 1'b0, pres_from, pres_to, 0, "R2", len, low);
      check(presence == 1'b1, "R3", presence, 1);
      run_op(2'd0, 1'b0, 0, 0, 0, "R4", len, low);
      check(presence == 1'b0, "R3", presence, 0);

      // directed writes and reads
      run_op(2'd1, 1'b0, 0, 0, 0, "R5", len, low);
      run_op(2'd1, 1'b1, 0, 0, 0, "R6", len, low);
      run_op(2'd2, 1'b0, 1, 30 * DIV, 0, "R7", len, low);
      check(rd_bit == 1'b0, "R7", rd_bit, 0);
      check(presence == 1'b0, "R7", presence, 0);
      run_op(2'd2, 1'b0, 0, 0, 0, "R7", len, low);
      check(rd_bit == 1'b1, "R7", rd_bit, 1);

      // start while busy: injected mid-slot with another code
      run_op(2'd1, 1'b0, 0, 0, 20, "R9", len, low);
      run_op(2'd2, 1'b1, 0, 0, 10, "R9", len, low);
      check(rd_bit == 1'b1, "R9", rd_bit, 1);

      // invalid code
      @(negedge clk);
      start = 1'b1; op = 2'd3;
      @(negedge clk);
      start = 1'b0;
      repeat (8) begin
         @(negedge clk);
         check(!busy && !pull_low, "R11", {busy, pull_low}, 0);
      end
      check(!done, "R11", done, 0);

      // constrained random slots
      for (int i = 0; i < 36; i++) begin
         o  = ($urandom % 2 == 0) ? 2'd1 : 2'd2;
         b  = 1'($urandom % 2);
         rv = 1'($urandom % 2);
         if (o == 2'd2 && !rv)
            run_op(o, b, 1, (20 + $urandom % 30) * DIV, 0, "R7", len, low);
         else
            run_op(o, b, 0, 0, 0, (o == 2'd1) ? (b ? "R6" : "R5") : "R7", len, low);
         if (o == 2'd2) check(rd_bit == rv, "R7", rd_bit, rv);
      end

      // one more reset with a present slave at the window edges
      run_op(2'd0, 1'b0, (T_RLOW + 60) * DIV, (T_RLOW + 75) * DIV, 0, "R4", len, low);
      check(presence == 1'b1, "R3", presence, 1);
      check(!pull_low, "R10", pull_low, 0);
      finish_run();
   end
endmodule